// File: doc/BRIEF.md
# Card command issue and response capture

This block sits between a register front end and an abstract card model. Software writes a 32-bit argument and an 11-bit command word. When the command word is written with its start flag set, the block sends one request to the card. The request carries the command index and the argument.

The card answers with a single completion pulse. That pulse carries an error flag, a byte count and up to sixteen response bytes. The block checks the count against the response type the command asked for. It packs the bytes into four 32-bit response words, most significant byte first. It then emits exactly one status-set pulse (sent, response-end or timeout) together with a pulse that asks the data engine to re-evaluate its transfer.

The card handshake has no back-pressure. The request is a one-cycle pulse issued only from idle, and while a command is outstanding the block simply waits for the completion pulse. Completion pulses that arrive while idle are dropped, and command writes that arrive while busy are dropped.

Top module: `cmd_issue_ctrl`

## Requirements
- R1: After reset the request, busy, status-set and kick outputs are 0, the command readback is 0 and all response words are 0.
- R2: The command word layout is: index in bits 5:0, response-expected in bit 6, long-response in bit 7, interrupt-mode in bit 8, pending-mode in bit 9 and start in bit 10. A command write from idle with start=1 and pending=0 raises `card_req_o` for exactly one cycle, in the cycle after the write. During that cycle `card_index_o` holds bits 5:0 and `card_arg_o` holds the last argument written, and `busy_o` is 1 until completion.
- R3: A command write with start=1 and pending=1 issues no request, does not set busy and gives no kick, and its readback shows start cleared.
- R4: A command write with start=0 is stored and reads back unchanged, and it issues no request.
- R5: On any completion the start bit of the readback clears, `busy_o` drops and `kick_o` pulses for one cycle. All of these are visible in the cycle after `card_done_i`.
- R6: When no response is expected, a completion without error pulses `set_sent_o`, and a completion with error pulses `set_timeout_o`.
- R7: When a response is expected, `set_timeout_o` pulses in any of these cases: the card flags an error, the length is 0, the length is 4 while a long response was requested, or the length is anything other than 4 or 16. In these cases the response words keep their previous values.
- R8: An accepted 4-byte response pulses `set_respend_o`. Response word 0 (bits 31:0 of `rsp_o`) takes `card_resp_i[127:96]`, with the first byte in bits 31:24, and words 1 to 3 become 0.
- R9: An accepted 16-byte response fills word k (`rsp_o[32k+31:32k]`) from `card_resp_i[127-32k -: 32]`, with bit 0 of word 3 forced to 0.
- R10: A command write while busy is ignored, and a completion pulse while idle is ignored.
- R11: Each completed command produces exactly one of the three status-set pulses, in the same cycle as the kick pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arg_we | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write data |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 11 | Command write data |
| cmd_word_o | output | 11 | Command register readback |
| busy_o | output | 1 | Command outstanding at the card |
| card_req_o | output | 1 | One-cycle request to the card |
| card_index_o | output | 6 | Command index toward the card |
| card_arg_o | output | 32 | Argument toward the card |
| card_done_i | input | 1 | Completion pulse from the card |
| card_err_i | input | 1 | Card error, valid with completion |
| card_len_i | input | 5 | Response byte count, valid with completion |
| card_resp_i | input | 128 | Response bytes, first byte in bits 127:120 |
| rsp_o | output | 128 | Response words, word k in bits 32k+31:32k |
| set_sent_o | output | 1 | Status set pulse: command sent |
| set_respend_o | output | 1 | Status set pulse: response received |
| set_timeout_o | output | 1 | Status set pulse: command timeout |
| kick_o | output | 1 | Pulse asking the data engine to re-evaluate |

## Verification
The assertions check several properties on every cycle:
- the request is a single-cycle pulse;
- every kick coincides with exactly one status-set pulse;
- start is clear whenever the block is idle;
- a write while busy leaves the command register untouched;
- a pending-mode start neither issues a request nor sets busy;
- a timeout leaves the response words stable;
- bit 0 of the last response word is never set.

Only the directed scenarios can show the values themselves. These are the byte order of short and long responses, the zeroing of the upper words on a short response, and the correct index and argument on the request. They also cover each separate timeout cause and the dropping of a completion that arrives while idle.

// File: rtl/cmdi_pkg.sv
package cmdi_pkg;
  localparam int CMD_W   = 11;
  localparam int IDX_W   = 6;
  localparam int CB_RESP = 6;
  localparam int CB_LONG = 7;
  localparam int CB_INTR = 8;
  localparam int CB_PEND = 9;
  localparam int CB_EN   = 10;

  typedef enum logic [1:0] {
    OC_NONE = 2'd0,
    OC_SENT = 2'd1,
    OC_RESP = 2'd2,
    OC_TMO  = 2'd3
  } outcome_e;
endpackage

// File: rtl/cmdi_judge.sv
module cmdi_judge #(
  parameter int LEN_W     = 5,
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 16
) (
  input  logic                 want_resp,
  input  logic                 want_long,
  input  logic                 err,
  input  logic [LEN_W-1:0]     len,
  output cmdi_pkg::outcome_e   outcome
);
  import cmdi_pkg::*;

  logic is_short, is_long, is_zero, bad_len, fail;

  always_comb begin
    is_short = (len == LEN_W'(SHORT_LEN));
    is_long  = (len == LEN_W'(LONG_LEN));
    is_zero  = (len == '0);
    bad_len  = is_zero || (is_short && want_long) || (!is_short && !is_long);
    fail     = err || (want_resp && bad_len);
    if (fail)           outcome = OC_TMO;
    else if (want_resp) outcome = OC_RESP;
    else                outcome = OC_SENT;
  end
endmodule

// File: rtl/cmdi_ctrl.sv
module cmdi_ctrl (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_we,
  input  logic [cmdi_pkg::CMD_W-1:0]   cmd_wdata,
  input  logic                         card_done_i,
  input  cmdi_pkg::outcome_e           outcome,
  output logic [cmdi_pkg::CMD_W-1:0]   cmd_q,
  output logic                         busy,
  output logic                         req,
  output logic                         set_sent,
  output logic                         set_respend,
  output logic                         set_timeout,
  output logic                         kick,
  output logic                         load_resp
);
  import cmdi_pkg::*;

  localparam logic [CMD_W-1:0] EN_CLR = ~(CMD_W'(1) << CB_EN);

  logic start_ok, finish;

  always_comb begin
    start_ok  = cmd_we && cmd_wdata[CB_EN] && !cmd_wdata[CB_PEND];
    finish    = busy && card_done_i;
    load_resp = finish && (outcome == OC_RESP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      busy        <= 1'b0;
      req         <= 1'b0;
      set_sent    <= 1'b0;
      set_respend <= 1'b0;
      set_timeout <= 1'b0;
      kick        <= 1'b0;
    end else begin
      req         <= 1'b0;
      set_sent    <= 1'b0;
      set_respend <= 1'b0;
      set_timeout <= 1'b0;
      kick        <= 1'b0;
      if (!busy) begin
        if (start_ok) begin
          cmd_q <= cmd_wdata;
          busy  <= 1'b1;
          req   <= 1'b1;
        end else if (cmd_we) begin
          cmd_q <= cmd_wdata & EN_CLR;
        end
      end else if (finish) begin
        cmd_q       <= cmd_q & EN_CLR;
        busy        <= 1'b0;
        kick        <= 1'b1;
        set_sent    <= (outcome == OC_SENT);
        set_respend <= (outcome == OC_RESP);
        set_timeout <= (outcome == OC_TMO);
      end
    end
  end

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> ($countones({set_sent, set_respend, set_timeout}) == 1));
  assert_status_needs_kick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_sent || set_respend || set_timeout) |-> kick);
  assert_idle_en_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_q[CB_EN]);
  assert_busy_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we && !card_done_i) |=> $stable(cmd_q));
  assert_pending_no_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_we && cmd_wdata[CB_EN] && cmd_wdata[CB_PEND]) |=> (!req && !busy && !kick));
endmodule

// File: rtl/cmdi_resp_store.sv
module cmdi_resp_store #(
  parameter int WORD_W    = 32,
  parameter int N_WORDS   = 4,
  parameter int LEN_W     = 5,
  parameter int SHORT_LEN = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [LEN_W-1:0]            len,
  input  logic [WORD_W*N_WORDS-1:0]   resp_in,
  output logic [WORD_W*N_WORDS-1:0]   rsp_q
);
  localparam int RESP_W = WORD_W * N_WORDS;

  logic short_len;
  assign short_len = (len == LEN_W'(SHORT_LEN));

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic [WORD_W-1:0] src, nxt;
    assign src = resp_in[RESP_W-1-k*WORD_W -: WORD_W];
    always_comb begin
      nxt = src;
      if (short_len && k != 0) nxt = '0;
      if (!short_len && k == N_WORDS-1) nxt[0] = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)    rsp_q[k*WORD_W +: WORD_W] <= '0;
      else if (load) rsp_q[k*WORD_W +: WORD_W] <= nxt;
    end
  end

  assert_last_lsb_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_q[(N_WORDS-1)*WORD_W]);
  assert_hold_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(rsp_q));
endmodule

// File: rtl/cmd_issue_ctrl.sv
module cmd_issue_ctrl #(
  parameter int ARG_W   = 32,
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int LEN_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arg_we,
  input  logic [ARG_W-1:0]           arg_wdata,
  input  logic                       cmd_we,
  input  logic [10:0]                cmd_wdata,
  output logic [10:0]                cmd_word_o,
  output logic                       busy_o,
  output logic                       card_req_o,
  output logic [5:0]                 card_index_o,
  output logic [ARG_W-1:0]           card_arg_o,
  input  logic                       card_done_i,
  input  logic                       card_err_i,
  input  logic [LEN_W-1:0]           card_len_i,
  input  logic [WORD_W*N_WORDS-1:0]  card_resp_i,
  output logic [WORD_W*N_WORDS-1:0]  rsp_o,
  output logic                       set_sent_o,
  output logic                       set_respend_o,
  output logic                       set_timeout_o,
  output logic                       kick_o
);
  import cmdi_pkg::*;

  localparam int SHORT_LEN = WORD_W / 8;
  localparam int LONG_LEN  = WORD_W * N_WORDS / 8;

  logic [ARG_W-1:0] arg_q;
  logic [CMD_W-1:0] cmd_q;
  outcome_e         outcome;
  logic             load_resp;

  always_ff @(posedge clk) begin
    if (!rst_n)      arg_q <= '0;
    else if (arg_we) arg_q <= arg_wdata;
  end

  cmdi_judge #(.LEN_W(LEN_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_judge (
    .want_resp (cmd_q[CB_RESP]),
    .want_long (cmd_q[CB_LONG]),
    .err       (card_err_i),
    .len       (card_len_i),
    .outcome   (outcome)
  );

  cmdi_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_wdata   (cmd_wdata),
    .card_done_i (card_done_i),
    .outcome     (outcome),
    .cmd_q       (cmd_q),
    .busy        (busy_o),
    .req         (card_req_o),
    .set_sent    (set_sent_o),
    .set_respend (set_respend_o),
    .set_timeout (set_timeout_o),
    .kick        (kick_o),
    .load_resp   (load_resp)
  );

  cmdi_resp_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .LEN_W(LEN_W), .SHORT_LEN(SHORT_LEN)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_resp),
    .len     (card_len_i),
    .resp_in (card_resp_i),
    .rsp_q   (rsp_o)
  );

  assign cmd_word_o   = cmd_q;
  assign card_index_o = cmd_q[IDX_W-1:0];
  assign card_arg_o   = arg_q;

  assert_tmo_keeps_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_timeout_o |-> $stable(rsp_o));
  assert_idle_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && card_done_i) |=> !kick_o);
endmodule

// File: tb/test_cmd_issue_ctrl.sv
module test_cmd_issue_ctrl;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0, rst_n = 0;
  logic         arg_we = 0, cmd_we = 0;
  logic [31:0]  arg_wdata = 0;
  logic [10:0]  cmd_wdata = 0;
  logic [10:0]  cmd_word_o;
  logic         busy_o, card_req_o, set_sent_o, set_respend_o, set_timeout_o, kick_o;
  logic [5:0]   card_index_o;
  logic [31:0]  card_arg_o;
  logic         card_done_i = 0, card_err_i = 0;
  logic [4:0]   card_len_i = 0;
  logic [127:0] card_resp_i = 0;
  logic [127:0] rsp_o;

  int n_checks = 0, n_fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_issue_ctrl i_cmd_issue_ctrl (
    .clk(clk), .rst_n(rst_n), .arg_we(arg_we), .arg_wdata(arg_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_word_o(cmd_word_o), .busy_o(busy_o),
    .card_req_o(card_req_o), .card_index_o(card_index_o), .card_arg_o(card_arg_o),
    .card_done_i(card_done_i), .card_err_i(card_err_i), .card_len_i(card_len_i),
    .card_resp_i(card_resp_i), .rsp_o(rsp_o), .set_sent_o(set_sent_o),
    .set_respend_o(set_respend_o), .set_timeout_o(set_timeout_o), .kick_o(kick_o)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_arg(input logic [31:0] a);
    arg_we = 1; arg_wdata = a;
    @(negedge clk); arg_we = 0;
  endtask

  task automatic wr_cmd(input logic [10:0] c);
    cmd_we = 1; cmd_wdata = c;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic card_done(input logic e, input logic [4:0] l, input logic [127:0] r);
    card_done_i = 1; card_err_i = e; card_len_i = l; card_resp_i = r;
    @(negedge clk); card_done_i = 0; card_err_i = 0;
  endtask

  task automatic chk_pulses(input string tag, input logic s, input logic re, input logic t, input logic k);
    chk(tag, {set_sent_o, set_respend_o, set_timeout_o, kick_o}, {s, re, t, k});
  endtask

  task automatic t_reset;
    chk("R1 busy/req", {busy_o, card_req_o}, 0);
    chk_pulses("R1 pulses", 0, 0, 0, 0);
    chk("R1 cmd readback", cmd_word_o, 0);
    chk("R1 response", rsp_o, 0);
  endtask

  task automatic t_no_resp;
    wr_arg(32'hCAFE_0001);
    wr_cmd(11'h400 | 11'd5);
    chk("R2 request", {card_req_o, busy_o}, 2'b11);
    chk("R2 index", card_index_o, 6'd5);
    chk("R2 argument", card_arg_o, 32'hCAFE_0001);
    @(negedge clk);
    chk("R2 single pulse", {card_req_o, busy_o}, 2'b01);
    card_done(0, 0, 0);
    chk_pulses("R6 sent", 1, 0, 0, 1);
    chk("R5 start cleared", cmd_word_o, 11'd5);
    chk("R5 idle", busy_o, 0);
    @(negedge clk);
    chk_pulses("R11 one cycle", 0, 0, 0, 0);
  endtask

  task automatic t_no_resp_err;
    wr_cmd(11'h400 | 11'd2);
    card_done(1, 0, 0);
    chk_pulses("R6 error timeout", 0, 0, 1, 1);
  endtask

  task automatic t_short;
    wr_cmd(11'h400 | 11'h040 | 11'd17);
    card_done(0, 5'd4, 128'h11223344_AAAAAAAA_BBBBBBBB_CCCCCCCC);
    chk_pulses("R8 respend", 0, 1, 0, 1);
    chk("R8 short words", rsp_o, {96'h0, 32'h11223344});
  endtask

  task automatic t_long;
    wr_cmd(11'h400 | 11'h0C0 | 11'd2);
    card_done(0, 5'd16, 128'h01020304_05060708_090A0B0C_0D0E0FFF);
    chk_pulses("R9 respend", 0, 1, 0, 1);
    chk("R9 long words", rsp_o, {32'h0D0E0FFE, 32'h090A0B0C, 32'h05060708, 32'h01020304});
  endtask

  task automatic t_timeouts;
    logic [127:0] keep;
    keep = {32'h0D0E0FFE, 32'h090A0B0C, 32'h05060708, 32'h01020304};
    wr_cmd(11'h440);
    card_done(1, 5'd16, '1);
    chk_pulses("R7 card error", 0, 0, 1, 1);
    wr_cmd(11'h440);
    card_done(0, 5'd0, '1);
    chk_pulses("R7 zero length", 0, 0, 1, 1);
    wr_cmd(11'h4C0);
    card_done(0, 5'd4, '1);
    chk_pulses("R7 short for long", 0, 0, 1, 1);
    wr_cmd(11'h440);
    card_done(0, 5'd8, '1);
    chk_pulses("R7 odd length", 0, 0, 1, 1);
    chk("R7 words kept", rsp_o, keep);
  endtask

  task automatic t_pending;
    wr_cmd(11'h600 | 11'd9);
    chk("R3 no request", {card_req_o, busy_o, kick_o}, 0);
    chk("R3 readback", cmd_word_o, 11'h200 | 11'd9);
    @(negedge clk);
    chk("R3 still idle", {card_req_o, busy_o, kick_o}, 0);
  endtask

  task automatic t_no_enable;
    wr_cmd(11'h1C3);
    chk("R4 readback", cmd_word_o, 11'h1C3);
    chk("R4 no request", {card_req_o, busy_o}, 0);
  endtask

  task automatic t_busy_block;
    wr_cmd(11'h400 | 11'd7);
    wr_cmd(11'h400 | 11'd33);
    chk("R10 write while busy", cmd_word_o, 11'h400 | 11'd7);
    chk("R10 no second request", card_req_o, 0);
    card_done(0, 0, 0);
    chk_pulses("R10 first completes", 1, 0, 0, 1);
    card_done(0, 5'd4, '1);
    chk_pulses("R10 idle done ignored", 0, 0, 0, 0);
    chk("R10 idle done words", rsp_o, {32'h0D0E0FFE, 32'h090A0B0C, 32'h05060708, 32'h01020304});
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_no_resp();
    t_no_resp_err();
    t_short();
    t_long();
    t_timeouts();
    t_pending();
    t_no_enable();
    t_busy_block();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule